// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Pipelined Stores

This block is the level-one data cache of a small in-order processor. It keeps sixteen lines, each holding a two-word block of 32-bit words. Each line also holds a valid bit, a dirty bit and a stored tag. Loads and stores arrive on a processor port. Each request carries its address, a write flag, a byte-or-word size flag and, for stores, the store data. The cache either answers in the same cycle or raises a stall until it can answer. The processor keeps its request steady while stall is high.

The cache follows a write-back policy and allocates a line on a store miss. A line is picked by the index bits of the address, and a hit needs the line to be valid with a matching tag. On a miss, a modified victim block is first sent to memory, and then the wanted block is fetched. Each of these transfers moves one 64-bit block and finishes when memory answers the request with an acknowledge, after any number of cycles.

A store that hits takes one cycle. Its data is parked in a one-entry holding register. It reaches the data array during the next store's tag check, or before any line fill. Loads that touch the parked word see its bytes.

Top module: `dmc_store_cache`

## Requirements
- R1: Address fields, from bit 0 upward: bits [1:0] pick the byte, bit [2] picks the word within the block, bits [6:3] pick one of 16 lines, and bits [15:7] form the tag. Two addresses that differ only in the tag map to the same line.
- R2: After reset no line is valid. With no request, stall and mem_req are low. The first access to any address is a miss that fetches its block.
- R3: A request hits only when its line is valid and the stored tag equals the address tag. A tag mismatch on a valid line is a miss. During a fill, mem_addr is the requested block address req_addr[15:3].
- R4: A word load returns the word chosen by bit 2. A byte load returns the byte chosen by bits [1:0] in rsp_rdata[7:0], with the upper 24 bits zero.
- R5: A store hit completes in one cycle, with stall low, and causes no memory transfer.
- R6: A load of a word that a not-yet-committed store has written returns that store's bytes, merged over the older contents by byte lane.
- R7: A store miss fetches the block first, then merges the store data into it and marks the line dirty. A fill ends with mem_req low in the following cycle.
- R8: Replacing a dirty line first writes its whole block, with every completed store in it, to the victim's block address {old tag, index}. The fill follows directly. Replacing a clean line causes no write-back.
- R9: Stall stays high in every cycle of a miss and is low in the cycle the result is delivered. mem_req, mem_we and mem_addr stay constant until mem_ack.
- R10: A block on the memory port carries word 0 in bits [31:0] and word 1 in bits [63:32], for both write-backs and fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Store data (byte stores use bits [7:0]) |
| rsp_valid | output | 1 | Load data delivered this cycle |
| rsp_rdata | output | 32 | Load data |
| stall | output | 1 | Request not finished this cycle |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 13 | Block address |
| mem_wdata | output | 64 | Write-back block |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rdata | input | 64 | Fill block, valid with mem_ack |

## Verification
The assertions check the memory handshake on every cycle. They check that a request is held until it is acknowledged, that a write-back is always followed by a fill of the requested block, and that the write-back index matches the request. They also check that a fill ends the transfer and that a non-stalled request leaves the memory port quiet. Whether the data is right can only be shown by the bench's scenarios. These cover byte-lane forwarding from the holding register, merges after a store-miss fill, write-back block contents, and clean versus dirty eviction. They sweep every line under several tags against an arithmetic memory image.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_check.sv
module dmc_tag_check #(
    parameter int TAG_W = 9
) (
    input  logic             line_vld,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] addr_tag,
    output logic             hit
);
    // R3: valid line and equal tag
    assign hit = line_vld && (line_tag == addr_tag);
endmodule

// File: rtl/dmc_store_lane.sv
module dmc_store_lane #(
    parameter int WORD_W = 32,
    localparam int BE_W = WORD_W / 8,
    localparam int BO_W = $clog2(BE_W)
) (
    input  logic              is_byte,
    input  logic [BO_W-1:0]   byte_off,
    input  logic [WORD_W-1:0] wdata,
    output logic [BE_W-1:0]   be,
    output logic [WORD_W-1:0] lane_data
);
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign be[b] = is_byte ? (byte_off == BO_W'(b)) : 1'b1;
        assign lane_data[b*8 +: 8] = is_byte ? wdata[7:0] : wdata[b*8 +: 8];
    end
endmodule

// File: rtl/dmc_load_align.sv
module dmc_load_align #(
    parameter int WORD_W = 32,
    localparam int BE_W = WORD_W / 8,
    localparam int BO_W = $clog2(BE_W)
) (
    input  logic [2*WORD_W-1:0] blk,
    input  logic                word_sel,
    input  logic [BO_W-1:0]     byte_off,
    input  logic                is_byte,
    input  logic                fwd_en,
    input  logic [BE_W-1:0]     fwd_be,
    input  logic [WORD_W-1:0]   fwd_dat,
    output logic [WORD_W-1:0]   rdata
);
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] merged;

    assign word = word_sel ? blk[2*WORD_W-1:WORD_W] : blk[WORD_W-1:0];

    // R6: bytes of the held store override the array copy
    for (genvar b = 0; b < BE_W; b++) begin : g_fwd
        assign merged[b*8 +: 8] = (fwd_en && fwd_be[b]) ? fwd_dat[b*8 +: 8] : word[b*8 +: 8];
    end

    // R4: byte loads are zero-extended
    assign rdata = is_byte ? {{(WORD_W-8){1'b0}}, merged[{byte_off, 3'b000} +: 8]} : merged;
endmodule

// File: rtl/dmc_store_cache.sv
module dmc_store_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINES  = 16,
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic                       req_byte,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [WORD_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [WORD_W-1:0]          rsp_rdata,
    output logic                       stall,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-$clog2(WORD_W/8)-2:0] mem_addr,
    output logic [2*WORD_W-1:0]        mem_wdata,
    input  logic                       mem_ack,
    input  logic [2*WORD_W-1:0]        mem_rdata
);
    localparam int BE_W     = WORD_W / 8;
    localparam int BO_W     = $clog2(BE_W);
    localparam int OFF_W    = BO_W + 1;
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W    = 2 * WORD_W;

    typedef struct packed {
        dmc_state_e                   st;
        logic [LINES-1:0]             vld;
        logic [LINES-1:0]             dty;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][BLK_W-1:0]  dat;
        logic                         p_vld;
        logic [IDX_W-1:0]             p_idx;
        logic                         p_word;
        logic [BE_W-1:0]              p_be;
        logic [WORD_W-1:0]            p_dat;
    } regs_t;

    regs_t regs_q, regs_d;

    // R1: address fields
    logic [BO_W-1:0]  a_byte;
    logic             a_word;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    assign a_byte = req_addr[BO_W-1:0];
    assign a_word = req_addr[BO_W];
    assign a_idx  = req_addr[OFF_W +: IDX_W];
    assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];

    logic             hit;
    logic             fwd_en;
    logic [BE_W-1:0]  st_be;
    logic [WORD_W-1:0] st_dat;
    logic [BLK_W-1:0] line_dat;

    assign line_dat = regs_q.dat[a_idx];
    assign fwd_en   = regs_q.p_vld && (regs_q.p_idx == a_idx) && (regs_q.p_word == a_word);

    dmc_tag_check #(.TAG_W(TAG_W)) u_tag (
        .line_vld (regs_q.vld[a_idx]),
        .line_tag (regs_q.tag[a_idx]),
        .addr_tag (a_tag),
        .hit      (hit)
    );

    dmc_store_lane #(.WORD_W(WORD_W)) u_lane (
        .is_byte   (req_byte),
        .byte_off  (a_byte),
        .wdata     (req_wdata),
        .be        (st_be),
        .lane_data (st_dat)
    );

    dmc_load_align #(.WORD_W(WORD_W)) u_align (
        .blk      (line_dat),
        .word_sel (a_word),
        .byte_off (a_byte),
        .is_byte  (req_byte),
        .fwd_en   (fwd_en),
        .fwd_be   (regs_q.p_be),
        .fwd_dat  (regs_q.p_dat),
        .rdata    (rsp_rdata)
    );

    logic idle;
    assign idle      = (regs_q.st == ST_IDLE);
    assign stall     = req_valid && !(idle && hit);
    assign rsp_valid = req_valid && idle && hit && !req_write;
    assign mem_req   = (regs_q.st == ST_WB) || (regs_q.st == ST_FILL);
    assign mem_we    = (regs_q.st == ST_WB);
    assign mem_addr  = mem_we ? {regs_q.tag[a_idx], a_idx} : {a_tag, a_idx};
    assign mem_wdata = line_dat;

    always_comb begin
        logic commit;
        regs_d = regs_q;
        commit = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (req_valid && hit && req_write) begin
                    // R5: hold the store, retire the previous one
                    commit          = regs_q.p_vld;
                    regs_d.p_vld    = 1'b1;
                    regs_d.p_idx    = a_idx;
                    regs_d.p_word   = a_word;
                    regs_d.p_be     = st_be;
                    regs_d.p_dat    = st_dat;
                    regs_d.dty[a_idx] = 1'b1;
                end else if (req_valid && !hit) begin
                    // drain before any line is evicted or refilled
                    commit       = regs_q.p_vld;
                    regs_d.p_vld = 1'b0;
                    regs_d.st    = (regs_q.vld[a_idx] && regs_q.dty[a_idx]) ? ST_WB : ST_FILL;
                end
            end
            ST_WB: begin
                if (mem_ack) regs_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    regs_d.dat[a_idx] = mem_rdata;
                    regs_d.tag[a_idx] = a_tag;
                    regs_d.vld[a_idx] = 1'b1;
                    regs_d.dty[a_idx] = 1'b0;
                    regs_d.st         = ST_IDLE;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
        if (commit) begin
            for (int b = 0; b < BE_W; b++) begin
                if (regs_q.p_be[b]) begin
                    regs_d.dat[regs_q.p_idx][int'(regs_q.p_word)*WORD_W + b*8 +: 8] =
                        regs_q.p_dat[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/dmc_store_cache_chk.sv
module dmc_store_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int MA_W   = 13,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [MA_W-1:0]   mem_addr
);
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

    a_r5_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !stall |-> !mem_req);

    a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    a_r7_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> !mem_req);

    a_r3_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mem_req && !mem_we |-> mem_addr == req_addr[ADDR_W-1:OFF_W]);

    a_r8_wb_index: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mem_req && mem_we |-> mem_addr[IDX_W-1:0] == req_addr[OFF_W +: IDX_W]);
endmodule

bind dmc_store_cache dmc_store_cache_chk #(
    .ADDR_W (ADDR_W),
    .MA_W   (ADDR_W - $clog2(WORD_W/8) - 1),
    .IDX_W  ($clog2(LINES)),
    .OFF_W  ($clog2(WORD_W/8) + 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .stall     (stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/dmc_store_cache_bench.sv
module dmc_store_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_byte = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        stall;
    logic        mem_req;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    int wb_cnt = 0;
    int fill_cnt = 0;
    int lat_cnt = 0;
    logic [31:0] ref_w [int];
    logic [63:0] mem_blk [int];

    always #4 clk = ~clk;

    dmc_store_cache u_dmc_store_cache (.*);

    function automatic logic [31:0] pat(input int wa);
        logic [15:0] w;
        w = 16'(wa);
        return {w ^ 16'h5A5A, ~w};
    endfunction

    function automatic logic [31:0] ref_rd(input int wa);
        return ref_w.exists(wa) ? ref_w[wa] : pat(wa);
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    // memory model: variable latency, checks write-back contents (R8, R10)
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (mem_req) begin
            if (lat_cnt == int'(mem_addr) % 3) begin
                int b;
                b = int'(mem_addr);
                mem_ack = 1'b1;
                if (mem_we) begin
                    wb_cnt++;
                    chk("R8 R10 write-back block", mem_wdata, {ref_rd(2*b+1), ref_rd(2*b)});
                    mem_blk[b] = mem_wdata;
                end else begin
                    fill_cnt++;
                    mem_rdata = mem_blk.exists(b) ? mem_blk[b] : {pat(2*b+1), pat(2*b)};
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic acc(input logic wr, input logic by, input logic [15:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = a; req_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            cyc++;
            if (!stall) break;
            @(negedge clk);
        end
        rd = rsp_rdata;
        if (!wr) chk("R9 rsp_valid with result", rsp_valid, 1'b1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (wr) begin
            int wa;
            logic [31:0] w;
            wa = int'(a >> 2);
            w = ref_rd(wa);
            if (by) w[8*a[1:0] +: 8] = wd[7:0];
            else    w = wd;
            ref_w[wa] = w;
        end
    endtask

    function automatic logic [31:0] exp_ld(input logic by, input logic [15:0] a);
        logic [31:0] w;
        w = ref_rd(int'(a >> 2));
        return by ? {24'b0, w[8*a[1:0] +: 8]} : w;
    endfunction

    task automatic ld_chk(input string rq, input logic by, input logic [15:0] a);
        logic [31:0] rd;
        int cyc;
        acc(1'b0, by, a, 32'h0, rd, cyc);
        chk(rq, rd, exp_ld(by, a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc, f0, w0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle stall", stall, 1'b0);
        chk("R2 idle mem_req", mem_req, 1'b0);

        // R2: cold miss fetches the block
        f0 = fill_cnt; w0 = wb_cnt;
        acc(1'b0, 1'b0, 16'h0040, 0, rd, cyc);
        chk("R2 cold miss fill", fill_cnt - f0, 1);
        chk("R9 miss stalls", cyc > 1, 1'b1);
        chk("R4 word0 data", rd, pat(16'h0040 >> 2));

        // R3 R10: second word of the line is a one-cycle hit
        f0 = fill_cnt;
        acc(1'b0, 1'b0, 16'h0044, 0, rd, cyc);
        chk("R3 hit one cycle", cyc, 1);
        chk("R3 hit no fill", fill_cnt - f0, 0);
        chk("R10 word1 data", rd, pat(16'h0044 >> 2));

        // R4: all byte offsets of both words
        for (int i = 0; i < 8; i++) ld_chk("R4 byte load", 1'b1, 16'h0040 + 16'(i));

        // R5: store hit
        f0 = fill_cnt; w0 = wb_cnt;
        acc(1'b1, 1'b0, 16'h0040, 32'hCAFE_0001, rd, cyc);
        chk("R5 store hit one cycle", cyc, 1);
        chk("R5 store hit no transfer", (fill_cnt - f0) + (wb_cnt - w0), 0);

        // R6: forwarding from the held store, then byte merge
        ld_chk("R6 forward word", 1'b0, 16'h0040);
        acc(1'b1, 1'b1, 16'h0042, 32'h0000_0077, rd, cyc);
        ld_chk("R6 forward byte merge", 1'b0, 16'h0040);
        ld_chk("R6 forward byte load", 1'b1, 16'h0042);
        acc(1'b1, 1'b0, 16'h0044, 32'h1234_5678, rd, cyc);
        ld_chk("R6 after commit word0", 1'b0, 16'h0040);

        // R1 R8: same index, other tag; dirty victim written back
        w0 = wb_cnt; f0 = fill_cnt;
        ld_chk("R1 R3 conflict load", 1'b0, 16'h0840);
        chk("R8 dirty write-back", wb_cnt - w0, 1);
        chk("R8 fill after write-back", fill_cnt - f0, 1);

        // R8: clean victim, no write-back; stored data came back through memory
        w0 = wb_cnt;
        ld_chk("R8 reload stored word0", 1'b0, 16'h0040);
        chk("R8 clean eviction", wb_cnt - w0, 0);
        ld_chk("R8 reload stored word1", 1'b0, 16'h0044);

        // R7: store miss allocates then merges
        f0 = fill_cnt;
        acc(1'b1, 1'b1, 16'h1011, 32'h0000_00AB, rd, cyc);
        chk("R7 store miss fill", fill_cnt - f0, 1);
        ld_chk("R7 merged word", 1'b0, 16'h1010);
        ld_chk("R7 other word kept", 1'b0, 16'h1014);
        w0 = wb_cnt;
        ld_chk("R7 line dirty evicts", 1'b0, 16'h3010);
        chk("R7 dirty after store miss", wb_cnt - w0, 1);

        // sweep: three tags over all lines and words, mixed operations
        for (int t = 0; t < 3; t++) begin
            for (int ix = 0; ix < 16; ix++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [15:0] a;
                    a = 16'((t << 7) | (ix << 3) | (w << 2) | (ix % 4));
                    case ((ix + t + w) % 3)
                        0: begin
                            acc(1'b1, 1'b0, a & 16'hFFFC, 32'(t * 4096 + ix * 16 + w), rd, cyc);
                            ld_chk("R5 R6 sweep word store", 1'b0, a & 16'hFFFC);
                        end
                        1: begin
                            acc(1'b1, 1'b1, a, 32'(ix * 9 + t), rd, cyc);
                            ld_chk("R6 sweep byte store", 1'b1, a);
                        end
                        default: ld_chk("R4 sweep load", 1'b1, a);
                    endcase
                end
            end
        end
        for (int t = 0; t < 3; t++)
            for (int ix = 0; ix < 16; ix++)
                for (int w = 0; w < 2; w++)
                    ld_chk("R8 sweep readback", 1'b0, 16'((t << 7) | (ix << 3) | (w << 2)));

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule